// File: doc/BRIEF.md
# Pin Interrupt and Wake Status Cell

This cell sits behind one general-purpose pin and decides when that pin has raised an interrupt or a wake-up event. It takes the already filtered pin level and samples it once per clock. It keeps a one-cycle-old copy of that level so that it can see edges. A two-bit trigger code and a level/edge select turn the pin activity into a single "active event" for each cycle.

The active event sets two sticky status bits. The interrupt status is set only while interrupt enable is high. The wake status is set only when the wake enable for the present power state is high. Software clears either bit by writing a one to its bit position in the pin's control word, so writing back a word that was read acknowledges exactly the status that was seen.

The interrupt request leaving the cell needs three things at once: the interrupt status, interrupt enable, and the unmask bit, which is active high. A separate service flag tells a bank-level summary that this pin has something pending, whether an interrupt or a wake. Reset is asynchronous and active low, and its release is synchronised to the clock inside the cell.

Top module: `gpio_pin_event_cell`

## Requirements
- R1: While reset is asserted, and until the reset release has been synchronised, the interrupt status, wake status, request and service outputs are all 0.
- R2: In edge mode (`lvl_mode`=0) the trigger code selects the event: 0 = falling edge (1 then 0 on consecutive samples), 1 = rising edge, 2 = either edge, 3 = no event. An event seen at a clock edge sets the status at that same edge.
- R3: In level mode (`lvl_mode`=1) the trigger code selects the event: 0 = pin low, 1 = pin high. Codes 2 and 3 produce no event.
- R4: A clear and a new event in the same cycle leave the status set, so in level mode the status stays 1 while the active level persists, even across clear writes.
- R5: With `irq_en`=0 no interrupt status is latched. A status that was already set is kept.
- R6: `irq_req` is 1 exactly when the interrupt status, `irq_en` and `irq_unmask` are all 1. `irq_unmask`=1 means unmasked.
- R7: A write (`wr_en`=1) with a 1 in bit 28 of `wr_data` clears the interrupt status. A 1 in bit 29 clears the wake status. Zeros in those bits, and all other bits, have no effect. The two clears act independently.
- R8: The wake status is set by an event only when the wake enable for the power state is 1. `pwr_state` 1 uses `wake_en[0]`, 2 uses `wake_en[1]`, 3 uses `wake_en[2]`, and 0 (running) never sets it. `irq_en` does not affect the wake status.
- R9: `svc_pending` is 1 exactly when the interrupt status or the wake status is 1.
- R10: The stored previous pin level resets to 0, so a pin held high through reset counts as a rising edge on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 1 | Filtered pin level |
| irq_en | input | 1 | Interrupt enable |
| irq_unmask | input | 1 | Interrupt unmask (1 = forward request) |
| lvl_mode | input | 1 | 1 = level sensing, 0 = edge sensing |
| trig_sel | input | 2 | Trigger code (see R2, R3) |
| wake_en | input | 3 | Wake enables for power states 1, 2, 3 |
| pwr_state | input | 2 | Present power state, 0 = running |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| irq_sts | output | 1 | Latched interrupt status |
| wake_sts | output | 1 | Latched wake status |
| irq_req | output | 1 | Forwarded interrupt request |
| svc_pending | output | 1 | Pin needs service |

## Verification
The hardest case to reach from the ports is a single clock edge that sees a chosen pair of previous and present pin levels, a chosen configuration, and status bits known to be clear. The previous level is internal and the status bits are sticky, so no edge can be placed cleanly without help. The stimulus therefore spends one preparation cycle for each case. In that cycle interrupts are disabled, the power state is running, the pin is driven to the first level and both clear bits are written. The next edge then applies the target configuration and the second level. This sweeps every combination of mode, code, enable, level pair, power state and wake-enable pattern, and compares the results against an arithmetic model.

// File: rtl/gpio_pin_event_pkg.sv
package gpio_pin_event_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW_FALL = 2'd0,
    TRIG_HIGH_RISE = 2'd1,
    TRIG_ANY_EDGE = 2'd2,
    TRIG_OFF = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    PWR_RUN = 2'd0,
    PWR_LIGHT = 2'd1,
    PWR_RAM = 2'd2,
    PWR_OFF = 2'd3
  } pwr_e;

  localparam int unsigned NUM_STS = 2;
  localparam int unsigned STS_IRQ = 0;
  localparam int unsigned STS_WAKE = 1;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_pin_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_lvl,
  input  logic       lvl_mode,
  input  logic [1:0] trig_sel,
  output logic       evt_hit
);
  logic prev_q, prev_d;
  logic rise, fall, edge_hit, level_hit;
  trig_e trig;

  assign trig = trig_e'(trig_sel);

  always_comb begin
    prev_d = pin_lvl;
    rise   = pin_lvl & ~prev_q;
    fall   = ~pin_lvl & prev_q;
    unique case (trig)
      TRIG_LOW_FALL:  begin edge_hit = fall;        level_hit = ~pin_lvl; end
      TRIG_HIGH_RISE: begin edge_hit = rise;        level_hit = pin_lvl;  end
      TRIG_ANY_EDGE:  begin edge_hit = rise | fall; level_hit = 1'b0;     end
      default:        begin edge_hit = 1'b0;        level_hit = 1'b0;     end
    endcase
    evt_hit = lvl_mode ? level_hit : edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/gpio_sticky_bit.sv
module gpio_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q, sts_d, sts_en;

  always_comb begin
    sts_en = set_i | clr_i;
    sts_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= 1'b0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/gpio_pin_event_cell.sv
module gpio_pin_event_cell
  import gpio_pin_event_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_CLR_POS = 28,
  parameter int unsigned WAKE_CLR_POS = 29,
  parameter int unsigned NUM_WAKE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_lvl,
  input  logic              irq_en,
  input  logic              irq_unmask,
  input  logic              lvl_mode,
  input  logic [1:0]        trig_sel,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic [1:0]        pwr_state,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_sts,
  output logic              wake_sts,
  output logic              irq_req,
  output logic              svc_pending
);
  localparam int unsigned CLR_POS [NUM_STS] = '{IRQ_CLR_POS, WAKE_CLR_POS};

  logic rst_sync_n;
  logic evt_hit;
  logic wake_arm;
  logic [NUM_STS-1:0] sts_set, sts_clr, sts_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_event_detect u_det (
    .clk(clk), .rst_n(rst_sync_n), .pin_lvl(pin_lvl),
    .lvl_mode(lvl_mode), .trig_sel(trig_sel), .evt_hit(evt_hit)
  );

  always_comb begin
    wake_arm = 1'b0;
    for (int s = 1; s <= NUM_WAKE; s++) begin
      if (int'(pwr_state) == s) wake_arm = wake_en[s-1];
    end
    sts_set[STS_IRQ]  = evt_hit & irq_en;
    sts_set[STS_WAKE] = evt_hit & wake_arm;
  end

  for (genvar g = 0; g < NUM_STS; g++) begin : g_sts
    assign sts_clr[g] = wr_en & wr_data[CLR_POS[g]];
    gpio_sticky_bit u_bit (
      .clk(clk), .rst_n(rst_sync_n), .set_i(sts_set[g]),
      .clr_i(sts_clr[g]), .sts_o(sts_q[g])
    );
  end

  assign irq_sts     = sts_q[STS_IRQ];
  assign wake_sts    = sts_q[STS_WAKE];
  assign irq_req     = sts_q[STS_IRQ] & irq_en & irq_unmask;
  assign svc_pending = |sts_q;
endmodule

// File: rtl/gpio_pin_event_chk.sv
module gpio_pin_event_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_CLR_POS = 28,
  parameter int unsigned WAKE_CLR_POS = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_lvl,
  input logic              irq_en,
  input logic              lvl_mode,
  input logic [1:0]        trig_sel,
  input logic [1:0]        pwr_state,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_sts,
  input logic              wake_sts
);
  assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && irq_en && trig_sel == 2'd1 && pin_lvl && !$past(pin_lvl)) |=> irq_sts);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && irq_en && trig_sel == 2'd1 && pin_lvl) |=> irq_sts);

  assert_no_latch_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_sts) |=> !irq_sts);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[IRQ_CLR_POS] && !irq_en) |=> !irq_sts);

  assert_wake_run_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[WAKE_CLR_POS] && pwr_state == 2'd0) |=> !wake_sts);
endmodule

bind gpio_pin_event_cell gpio_pin_event_chk #(
  .DATA_W(DATA_W), .IRQ_CLR_POS(IRQ_CLR_POS), .WAKE_CLR_POS(WAKE_CLR_POS)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pin_lvl(pin_lvl), .irq_en(irq_en),
  .lvl_mode(lvl_mode), .trig_sel(trig_sel), .pwr_state(pwr_state),
  .wr_en(wr_en), .wr_data(wr_data), .irq_sts(irq_sts), .wake_sts(wake_sts)
);

// File: tb/gpio_pin_event_cell_tb.sv
module gpio_pin_event_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_lvl, irq_en, irq_unmask, lvl_mode, wr_en;
  logic [1:0]  trig_sel, pwr_state;
  logic [2:0]  wake_en;
  logic [31:0] wr_data;
  logic        irq_sts, wake_sts, irq_req, svc_pending;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  localparam logic [31:0] CLR_IRQ  = 32'h1000_0000;
  localparam logic [31:0] CLR_WAKE = 32'h2000_0000;

  always #2 clk = ~clk;

  gpio_pin_event_cell u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq_en(irq_en),
    .irq_unmask(irq_unmask), .lvl_mode(lvl_mode), .trig_sel(trig_sel),
    .wake_en(wake_en), .pwr_state(pwr_state), .wr_en(wr_en), .wr_data(wr_data),
    .irq_sts(irq_sts), .wake_sts(wake_sts), .irq_req(irq_req),
    .svc_pending(svc_pending)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_lvl = 1'b1; irq_en = 1'b1; irq_unmask = 1'b1;
    lvl_mode = 1'b0; trig_sel = 2'd1; pwr_state = 2'd0; wake_en = 3'b0;
    wr_en = 1'b0; wr_data = '0;
    repeat (3) step();
    // R1: reset state
    chk(irq_sts, 1'b0, "R1 irq_sts");
    chk(wake_sts, 1'b0, "R1 wake_sts");
    chk(irq_req, 1'b0, "R1 irq_req");
    chk(svc_pending, 1'b0, "R1 svc_pending");
    rst_n = 1'b1;
    step();
    chk(irq_sts, 1'b0, "R1 sync release");
    repeat (2) step();
    // R10: pin high through reset seen as rising edge
    chk(irq_sts, 1'b1, "R10 rise after reset");

    // Sweep: R2 R3 R5 R6 R8 R9
    for (int lv = 0; lv < 2; lv++)
      for (int a = 0; a < 4; a++)
        for (int en = 0; en < 2; en++)
          for (int p0 = 0; p0 < 2; p0++)
            for (int p1 = 0; p1 < 2; p1++)
              for (int ps = 0; ps < 4; ps++)
                for (int we = 0; we < 8; we++) begin
                  logic hit, warm, e_irq, e_wake;
                  irq_en = 1'b0; pwr_state = 2'd0; pin_lvl = p0[0];
                  lvl_mode = lv[0]; trig_sel = a[1:0]; irq_unmask = 1'b0;
                  wr_en = 1'b1; wr_data = CLR_IRQ | CLR_WAKE;
                  step();
                  wr_en = 1'b0; wr_data = '0;
                  irq_en = en[0]; pwr_state = ps[1:0]; wake_en = we[2:0];
                  pin_lvl = p1[0];
                  step();
                  if (lv == 0)
                    hit = (a == 0 && p0 == 1 && p1 == 0) || (a == 1 && p0 == 0 && p1 == 1)
                          || (a == 2 && p0 != p1);
                  else
                    hit = (a == 0 && p1 == 0) || (a == 1 && p1 == 1);
                  warm = (ps == 0) ? 1'b0 : we[ps-1];
                  e_irq = hit & en[0];
                  e_wake = hit & warm;
                  chk(irq_sts, e_irq, lv ? "R3/R5 irq_sts" : "R2/R5 irq_sts");
                  chk(wake_sts, e_wake, "R8 wake_sts");
                  chk(svc_pending, e_irq | e_wake, "R9 svc_pending");
                  chk(irq_req, 1'b0, "R6 masked req");
                  irq_unmask = 1'b1;
                  #1;
                  chk(irq_req, e_irq & en[0], "R6 unmasked req");
                end

    // R4: level persists across clear
    lvl_mode = 1'b1; trig_sel = 2'd1; irq_en = 1'b1; pin_lvl = 1'b1; pwr_state = 2'd0;
    step();
    chk(irq_sts, 1'b1, "R4 level set");
    wr_en = 1'b1; wr_data = CLR_IRQ;
    step();
    chk(irq_sts, 1'b1, "R4 set beats clear");
    pin_lvl = 1'b0;
    step();
    wr_en = 1'b0;
    chk(irq_sts, 1'b0, "R4 clear once inactive");

    // R5: disabling keeps old status
    pin_lvl = 1'b1;
    step();
    irq_en = 1'b0;
    step();
    chk(irq_sts, 1'b1, "R5 kept while disabled");
    chk(irq_req, 1'b0, "R6 disabled no req");

    // R7: independent clears, zero writes ignored
    lvl_mode = 1'b0; trig_sel = 2'd1; irq_en = 1'b1; pwr_state = 2'd2; wake_en = 3'b010;
    pin_lvl = 1'b0; wr_en = 1'b1; wr_data = CLR_IRQ | CLR_WAKE;
    step();
    wr_en = 1'b0; pin_lvl = 1'b1;
    step();
    chk(irq_sts, 1'b1, "R7 pre irq");
    chk(wake_sts, 1'b1, "R7 pre wake");
    wr_en = 1'b1; wr_data = ~(CLR_IRQ | CLR_WAKE);
    step();
    chk(irq_sts, 1'b1, "R7 other bits ignored irq");
    chk(wake_sts, 1'b1, "R7 other bits ignored wake");
    wr_data = CLR_IRQ;
    step();
    chk(irq_sts, 1'b0, "R7 irq cleared");
    chk(wake_sts, 1'b1, "R7 wake kept");
    wr_data = CLR_WAKE;
    step();
    chk(wake_sts, 1'b0, "R7 wake cleared");
    chk(svc_pending, 1'b0, "R9 nothing pending");
    wr_en = 1'b0;
    wr_data = '0;
    step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule